// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external machine cycles of a small 8-bit processor. The processor has a 16-bit address, and its low address byte shares pins with the data byte. The core offers a request made of a cycle kind, an address and write data. The controller accepts the request only while it is idle or halted. It then steps through its T-states:

- **T1**: sends out the address and pulses the address latch strobe.
- **T2**: asserts the correct active-low strobe.
- **TW**: inserts wait states while the peripheral holds READY low.
- **T3**: completes the transfer.
- **T4**: an opcode fetch adds this extra state before the bus goes idle.

Read data is captured as the strobe ends. It is returned with a one-cycle completion pulse. A halt request parks the bus, floats the strobes and holds there until the next request.

The state machine has seven states:

| State | Role | Leaves to |
|-------|------|-----------|
| `ST_IDLE` | Waits for a request | `ST_T1`, or `ST_HALT` if the request is a halt |
| `ST_HALT` | Bus parked | `ST_T1` or `ST_HALT` on a new request |
| `ST_T1` | Address phase | `ST_T2` always |
| `ST_T2` | Strobe asserted | `ST_T3` when READY is high, else `ST_TW` |
| `ST_TW` | Wait state | `ST_T3` when READY is high, else stays in `ST_TW` |
| `ST_T3` | Transfer completes | `ST_T4` for an opcode fetch, else `ST_IDLE` |
| `ST_T4` | Fetch tail | `ST_IDLE` always |

Top module: `bcc_bus_ctrl`

## Requirements
- R1: After reset:
  - `req_accept` is 1, `ale` is 0, `ad_oe` is 0 and `done` is 0.
  - `rd_n`, `wr_n` and `inta_n` are 1, and `ctl_oe` is 1.
  - `{io_m,s1,s0}` reads 3'b010.
- R2: `ale` is high for exactly one cycle per machine cycle, the T1 state. During T1:
  - `ad_oe` is 1 and `ad_out` carries address bits 7:0.
  - `addr_hi` carries address bits 15:8, and holds them for the rest of the cycle.
- R3: From T1 to the end of the cycle, `{io_m,s1,s0}` follows the request kind `req_type`:

  | `req_type` | Cycle | `{io_m,s1,s0}` |
  |------------|-------|----------------|
  | 0 | opcode fetch | 011 |
  | 1 | memory read | 010 |
  | 2 | memory write | 001 |
  | 3 | I/O read | 110 |
  | 4 | I/O write | 101 |
  | 5 | interrupt acknowledge | 111 |
  | 7 | reserved; behaves as a memory read | 010 |

- R4: Strobes are active from T2 through any wait states and T3, and are high in all other states:
  - Kinds 0, 1, 3 and 7 drive `rd_n` low.
  - Kind 5 drives `inta_n` low.
  - Kinds 2 and 4 drive `wr_n` low.
  - At most one strobe is low at any time.
- R5: In write cycles, `ad_oe` is 1 from T2 through T3 and `ad_out` carries the write data. In all other cycles, `ad_oe` is 0 after T1.
- R6: READY is sampled at the end of T2 and at the end of each wait state. Each low sample inserts one more wait state with the strobe held. READY has no effect in any other state.
- R7: `done` pulses for one cycle, in the cycle after T3. For read and acknowledge kinds, `rdata` then holds the value of `ad_in` at the end of T3.
- R8: An opcode fetch spends one T4 cycle after T3 with `req_accept` low; every other kind returns to idle right after T3. A request offered while `req_accept` is 0 is ignored.
- R9: A request of kind 6 (halt) puts the bus in a halted state and keeps it there until the next request. In that state:
  - `{io_m,s1,s0}` is 000, `ctl_oe` is 0 and `ad_oe` is 0.
  - The strobes are high, and `req_accept` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a request |
| req_type | input | 3 | Cycle kind code (see R3, R9) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Data for write kinds |
| req_accept | output | 1 | Request taken this cycle if valid (idle or halted) |
| ready | input | 1 | Peripheral ready; low stretches the cycle |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared bus value: low address in T1, write data later |
| ad_oe | output | 1 | Output enable for the shared bus |
| ad_in | input | 8 | Value read from the shared bus |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | High for I/O space, low for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| inta_n | output | 1 | Active-low interrupt acknowledge strobe |
| ctl_oe | output | 1 | Enable for the strobe drivers; 0 floats them in halt |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a long wait-state stretch. Many READY-low samples must land exactly on T2 and TW boundaries, while READY also toggles freely during T1 and T3, where it must be ignored. The bench drives READY per cycle from a per-transfer wait count. It pairs a directed twelve-wait fetch with random counts and random READY noise in the non-sampling states. Halt entry, halt followed by halt, and requests offered mid-cycle are forced through directed sequences.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4,
        CYC_INTA  = 3'd5,
        CYC_HALT  = 3'd6,
        CYC_RSVD  = 3'd7
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_T4,
        ST_HALT
    } st_e;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } stat_t;

endpackage

// File: rtl/bcc_status_enc.sv
module bcc_status_enc
    import bcc_pkg::*;
(
    input  cyc_e  cyc,
    output stat_t code,
    output logic  is_rd,
    output logic  is_wr,
    output logic  is_ack,
    output logic  has_t4
);
    always_comb begin
        code   = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
        is_rd  = 1'b0;
        is_wr  = 1'b0;
        is_ack = 1'b0;
        has_t4 = 1'b0;
        unique case (cyc)
            CYC_FETCH: begin
                code   = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
                is_rd  = 1'b1;
                has_t4 = 1'b1;
            end
            CYC_MRD, CYC_RSVD: begin
                code  = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
                is_rd = 1'b1;
            end
            CYC_MWR: begin
                code  = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
                is_wr = 1'b1;
            end
            CYC_IORD: begin
                code  = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
                is_rd = 1'b1;
            end
            CYC_IOWR: begin
                code  = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
                is_wr = 1'b1;
            end
            CYC_INTA: begin
                code   = '{io_m: 1'b1, s1: 1'b1, s0: 1'b1};
                is_ack = 1'b1;
            end
            CYC_HALT: begin
                code = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
            end
        endcase
    end
endmodule

// File: rtl/bcc_fsm.sv
module bcc_fsm
    import bcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic go_halt,
    input  logic ready,
    input  logic has_t4,
    output st_e  st
);
    st_e nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE, ST_HALT: begin
                if (start) nx = go_halt ? ST_HALT : ST_T1;
            end
            ST_T1:        nx = ST_T2;
            ST_T2, ST_TW: nx = ready ? ST_T3 : ST_TW;
            ST_T3:        nx = has_t4 ? ST_T4 : ST_IDLE;
            ST_T4:        nx = ST_IDLE;
            default:      nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bcc_bus_ctrl.sv
module bcc_bus_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_type,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_accept,
    input  logic                     ready,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n,
    output logic                     ctl_oe,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);
    localparam int HI_W = ADDR_W - DATA_W;

    st_e               st;
    cyc_e              cur_type;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    stat_t             code;
    logic              is_rd, is_wr, is_ack, has_t4;
    logic              start, strobe_phase;

    assign start = req_accept & req_valid;

    bcc_status_enc u_enc (
        .cyc    (cur_type),
        .code   (code),
        .is_rd  (is_rd),
        .is_wr  (is_wr),
        .is_ack (is_ack),
        .has_t4 (has_t4)
    );

    bcc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .go_halt (cyc_e'(req_type) == CYC_HALT),
        .ready   (ready),
        .has_t4  (has_t4),
        .st      (st)
    );

    // request capture and read-data return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_type  <= CYC_MRD;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rdata     <= '0;
            done      <= 1'b0;
        end else begin
            if (start) begin
                cur_type  <= cyc_e'(req_type);
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
            end
            done <= (st == ST_T3);
            if (st == ST_T3 && (is_rd || is_ack)) rdata <= ad_in;
        end
    end

    // pin outputs decoded from the state
    always_comb begin
        req_accept   = (st == ST_IDLE) || (st == ST_HALT);
        strobe_phase = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
        ale          = (st == ST_T1);
        ad_oe        = (st == ST_T1) || (strobe_phase && is_wr);
        ad_out       = (st == ST_T1) ? cur_addr[DATA_W-1:0] : cur_wdata;
        addr_hi      = cur_addr[ADDR_W-1 -: HI_W];
        rd_n         = !(strobe_phase && is_rd);
        wr_n         = !(strobe_phase && is_wr);
        inta_n       = !(strobe_phase && is_ack);
        ctl_oe       = (st != ST_HALT);
        io_m         = code.io_m;
        s1           = code.s1;
        s0           = code.s0;
    end
endmodule

// File: rtl/bcc_bus_chk.sv
module bcc_bus_chk
    import bcc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input st_e  st,
    input logic ready,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic inta_n,
    input logic ad_oe,
    input logic done,
    input logic req_accept
);
    // R2
    ale_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1);

    // R5
    wdata_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    // R6
    ready_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T2 || st == ST_TW) && !ready) |=> (st == ST_TW));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    ale_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(req_accept));
endmodule

bind bcc_bus_ctrl bcc_bus_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .ready      (ready),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .inta_n     (inta_n),
    .ad_oe      (ad_oe),
    .done       (done),
    .req_accept (req_accept)
);

// File: tb/sim_bcc_bus_ctrl.sv
`timescale 1ns/1ps
module sim_bcc_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_type = 3'd1;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_accept;
    logic        ready = 1'b1;
    logic [7:0]  addr_hi, ad_out, ad_in = '0, rdata;
    logic        ad_oe, ale, io_m, s1, s0, rd_n, wr_n, inta_n, ctl_oe, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bcc_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
        .ready(ready), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n),
        .wr_n(wr_n), .inta_n(inta_n), .ctl_oe(ctl_oe), .rdata(rdata), .done(done)
    );

    function automatic logic [2:0] exp_code(input logic [2:0] t);
        case (t)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            3'd5: return 3'b111;
            3'd6: return 3'b000;
            default: return 3'b010;
        endcase
    endfunction

    function automatic bit kind_rd(input logic [2:0] t);
        return (t == 3'd0 || t == 3'd1 || t == 3'd3 || t == 3'd7);
    endfunction

    function automatic bit kind_wr(input logic [2:0] t);
        return (t == 3'd2 || t == 3'd4);
    endfunction

    // expected {rd_n, wr_n, inta_n} while the strobe is active
    function automatic logic [2:0] exp_strobes(input logic [2:0] t);
        if (kind_rd(t)) return 3'b011;
        if (kind_wr(t)) return 3'b101;
        if (t == 3'd5)  return 3'b110;
        return 3'b111;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one full machine cycle; call at a negedge with the bus idle or halted
    task automatic do_cycle(input logic [2:0] t, input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] rv, input int nw, input bit poke);
        chk("R8 accept before request", req_accept, 1'b1);
        req_valid = 1'b1; req_type = t; req_addr = a; req_wdata = wd;
        ready = 1'($urandom);                       // R6: ignored while idle
        @(negedge clk);
        req_valid = 1'b0; req_type = 3'($urandom);
        if (t == 3'd6) begin
            chk("R9 halt status", {io_m, s1, s0}, 3'b000);
            chk("R9 halt ctl_oe", ctl_oe, 1'b0);
            chk("R9 halt ad_oe", ad_oe, 1'b0);
            chk("R9 halt strobes", {rd_n, wr_n, inta_n}, 3'b111);
            chk("R9 halt accept", req_accept, 1'b1);
            return;
        end
        // T1
        chk("R2 ale in T1", ale, 1'b1);
        chk("R2 ad_oe in T1", ad_oe, 1'b1);
        chk("R2 low address", ad_out, a[7:0]);
        chk("R2 high address", addr_hi, a[15:8]);
        chk("R3 status T1", {io_m, s1, s0}, exp_code(t));
        chk("R4 strobes idle in T1", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R8 busy in T1", req_accept, 1'b0);
        ready = 1'($urandom);                       // R6: ignored in T1
        @(negedge clk);
        // T2
        chk("R2 ale low T2", ale, 1'b0);
        chk("R4 strobe T2", {rd_n, wr_n, inta_n}, exp_strobes(t));
        chk("R5 ad_oe T2", ad_oe, kind_wr(t));
        if (kind_wr(t)) chk("R5 wdata T2", ad_out, wd);
        chk("R3 status T2", {io_m, s1, s0}, exp_code(t));
        if (poke) begin
            req_valid = 1'b1; req_type = 3'd6;      // R8: must be ignored
        end
        ready = (nw == 0);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            chk("R6 strobe held in wait", {rd_n, wr_n, inta_n}, exp_strobes(t));
            chk("R6 no done in wait", done, 1'b0);
            chk("R2 high address held", addr_hi, a[15:8]);
            ready = (i == nw - 1);
        end
        @(negedge clk);
        // T3
        req_valid = 1'b0;
        chk("R4 strobe T3", {rd_n, wr_n, inta_n}, exp_strobes(t));
        chk("R5 ad_oe T3", ad_oe, kind_wr(t));
        chk("R7 no done in T3", done, 1'b0);
        ad_in = rv;
        ready = 1'($urandom);                       // R6: ignored in T3
        @(negedge clk);
        chk("R7 done pulse", done, 1'b1);
        if (kind_rd(t) || t == 3'd5) chk("R7 rdata", rdata, rv);
        chk("R4 strobes released", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R5 ad_oe off", ad_oe, 1'b0);
        ad_in = 8'($urandom);
        if (t == 3'd0) begin
            chk("R8 fetch T4 busy", req_accept, 1'b0);
            chk("R3 status T4", {io_m, s1, s0}, exp_code(t));
            @(negedge clk);
            chk("R7 done single", done, 1'b0);
        end
        chk("R8 back to idle", req_accept, 1'b1);
        chk("R8 not halted", ctl_oe, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0085));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 accept", req_accept, 1'b1);
        chk("R1 ale", ale, 1'b0);
        chk("R1 ad_oe", ad_oe, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 strobes", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R1 ctl_oe", ctl_oe, 1'b1);
        chk("R1 status", {io_m, s1, s0}, 3'b010);

        // directed: every kind without waits
        for (int k = 0; k < 8; k++) begin
            if (k != 6) do_cycle(3'(k), 16'hA55A ^ 16'(k * 16'h1111), 8'h3C + 8'(k), 8'hC3 - 8'(k), 0, 1'b0);
        end
        // R6 long stretch on a fetch, and a one-wait write
        do_cycle(3'd0, 16'hFFFF, 8'h00, 8'h7E, 12, 1'b0);
        do_cycle(3'd4, 16'h0000, 8'hE7, 8'h00, 1, 1'b0);
        // R8 request offered mid-cycle is ignored
        do_cycle(3'd1, 16'h1234, 8'h00, 8'h99, 2, 1'b1);
        // R9 halt, stay halted, halt again, then leave
        do_cycle(3'd6, 16'h0, 8'h0, 8'h0, 0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 halt persists", {ctl_oe, io_m, s1, s0}, 4'b0000);
        end
        do_cycle(3'd6, 16'h0, 8'h0, 8'h0, 0, 1'b0);
        do_cycle(3'd5, 16'h0038, 8'h00, 8'hCF, 1, 1'b0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] t;
            int nw;
            t  = 3'($urandom_range(0, 7));
            nw = ($urandom_range(0, 9) == 0) ? int'($urandom_range(4, 10)) : int'($urandom_range(0, 2));
            do_cycle(t, 16'($urandom), 8'($urandom), 8'($urandom), nw, 1'($urandom_range(0, 3) == 0));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule